// File: doc/BRIEF.md
# Power-Up Sequencer with Strap Capture

This block brings the measurement logic of an energy metering chip out of reset in a fixed order. It keeps everything idle while the analog supply is reported low or while the external active-low reset pin is held. Both conditions are combined into an asynchronous reset that is released through a two-flop synchroniser. After release it counts a short settling window of master clock periods for the oscillator. It then reads the static strap pins once: the current-channel gain select, the pulse-rate select and the high-pass filter pin. Finally it raises a run enable for the measurement datapath.

The high-pass filter pin has three meanings. Tied high, no filter is used. Tied low, the filter acts on the voltage channel. Wired to the calibration pulse output, the filter acts on the current channel. To tell the third case apart, the block takes ownership of the calibration output during capture. It drives that output high for one sampling window and then low for a second one, and it watches whether the filter pin follows both levels. The filter pin is sampled through a synchroniser, so each probe level is held long enough to pass through it. The captured settings stay frozen until the next reset.

Top module: `pwrup_cfg_ctrl`

## Requirements
- R1: While `supply_ok` is low, the outputs hold their reset values: `run_en`=0, `cal_probe_en`=0, `cal_probe_lvl`=0, `cfg_gain_x`=0, `cfg_rate`=0, `cfg_hpf`=2'b00.
- R2: `ext_rst_n` low forces the same reset values without waiting for a clock edge, and holds them for as long as it stays low, even with `supply_ok` high.
- R3: Once both `supply_ok` and `ext_rst_n` are high, `run_en` stays 0 through the first 15 rising edges and becomes 1 after the 16th rising edge. The 16 edges are made up of 2 synchroniser edges, 8 settling edges and two probe windows of 3 edges each.
- R4: `cfg_gain_x` holds the decoded gain multiplier of `gain_sel`, sampled at capture: 2'b00 gives 10, 2'b01 gives 50, 2'b10 gives 100 and 2'b11 gives 150.
- R5: `cfg_rate` holds the value of `rate_sel` sampled at capture, unchanged.
- R6: If `hpf_pin` reads high in both probe windows, `cfg_hpf` is 2'b00 (no filter).
- R7: If `hpf_pin` reads low in both probe windows, `cfg_hpf` is 2'b01 (voltage-channel filter).
- R8: If `hpf_pin` reads high while the probe drives high and low while it drives low, `cfg_hpf` is 2'b10 (current-channel filter).
- R9: `cal_probe_en` is 1 from rising edge 10 through rising edge 15 after release, and 0 outside that span. During the first three of those cycles `cal_probe_lvl` is 1, during the last three it is 0, and it is 0 whenever `cal_probe_en` is 0.
- R10: Once `run_en` is 1, changes on `gain_sel`, `rate_sel` and `hpf_pin` leave `cfg_gain_x`, `cfg_rate`, `cfg_hpf` and `run_en` unchanged.
- R11: A new power-up after `supply_ok` falls and rises again captures the strap values present at that time.
- R12: A filter pin that reads low while the probe drives high and high while it drives low does not count as tied; `cfg_hpf` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| supply_ok | input | 1 | Analog supply above threshold, from the supply monitor |
| ext_rst_n | input | 1 | External reset pin, active low |
| gain_sel | input | 2 | Current-channel gain strap |
| rate_sel | input | 3 | Pulse-rate strap |
| hpf_pin | input | 1 | High-pass filter strap, possibly wired to the calibration output |
| cal_probe_en | output | 1 | Block owns the calibration output during capture |
| cal_probe_lvl | output | 1 | Level to drive on the calibration output while owned |
| cfg_gain_x | output | 8 | Latched gain multiplier |
| cfg_rate | output | 3 | Latched pulse-rate select |
| cfg_hpf | output | 2 | Latched filter mode: 00 none, 01 voltage, 10 current |
| run_en | output | 1 | Measurement enable |

## Verification
The hardest case to produce is the tied filter pin. The pin has to echo the probe level through a synchroniser, so a fixed strap value can never produce it. The bench models the board wiring with a continuous assignment that returns `cal_probe_lvl` on `hpf_pin`. It also models the inverted echo, which must not be taken as a tie. The settling and probe windows are checked edge by edge after release, so a window that is one cycle short or long is reported.

// File: rtl/pwrup_cfg_pkg.sv
package pwrup_cfg_pkg;

  typedef enum logic [1:0] {
    HPF_NONE = 2'b00,
    HPF_VCH  = 2'b01,
    HPF_ICH  = 2'b10
  } hpf_mode_e;

  typedef enum logic [1:0] {
    ST_SETTLE   = 2'b00,
    ST_PROBE_HI = 2'b01,
    ST_PROBE_LO = 2'b10,
    ST_RUN      = 2'b11
  } seq_state_e;

  localparam int GAIN_W = 8;

  function automatic logic [GAIN_W-1:0] gain_mult(input logic [1:0] code);
    logic [GAIN_W-1:0] m;
    case (code)
      2'b00:   m = GAIN_W'(10);
      2'b01:   m = GAIN_W'(50);
      2'b10:   m = GAIN_W'(100);
      default: m = GAIN_W'(150);
    endcase
    return m;
  endfunction

  // Pin followed the probe in both windows -> wired to calibration output.
  function automatic hpf_mode_e hpf_decode(input logic seen_hi, input logic seen_lo);
    hpf_mode_e m;
    if (seen_hi && !seen_lo)  m = HPF_ICH;
    else if (seen_lo)         m = HPF_NONE;
    else                      m = HPF_VCH;
    return m;
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int   STAGES  = 2,
  parameter int   WIDTH   = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d[b]};
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= {STAGES{RST_VAL}};
      else         chain_q <= chain_d;
    end

    assign q[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import pwrup_cfg_pkg::*;
#(
  parameter int SETTLE_CYC = 8,
  parameter int PROBE_LEN  = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic probe_en,
  output logic probe_lvl,
  output logic cap_cfg,
  output logic cap_hi,
  output logic cap_lo,
  output logic run_en
);

  localparam int CNT_MAX = (SETTLE_CYC > PROBE_LEN) ? SETTLE_CYC : PROBE_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] PROBE_LAST  = CNT_W'(PROBE_LEN - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    cnt_en  = 1'b1;
    cap_cfg = 1'b0;
    cap_hi  = 1'b0;
    cap_lo  = 1'b0;
    case (state_q)
      ST_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          state_d = ST_PROBE_HI;
          cnt_d   = '0;
          cap_cfg = 1'b1;
        end
      end
      ST_PROBE_HI: begin
        if (cnt_q == PROBE_LAST) begin
          state_d = ST_PROBE_LO;
          cnt_d   = '0;
          cap_hi  = 1'b1;
        end
      end
      ST_PROBE_LO: begin
        if (cnt_q == PROBE_LAST) begin
          state_d = ST_RUN;
          cnt_d   = '0;
          cap_lo  = 1'b1;
        end
      end
      default: begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SETTLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign probe_en  = (state_q == ST_PROBE_HI) || (state_q == ST_PROBE_LO);
  assign probe_lvl = (state_q == ST_PROBE_HI);
  assign run_en    = (state_q == ST_RUN);

endmodule

// File: rtl/cfg_latch.sv
module cfg_latch
  import pwrup_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_cfg,
  input  logic              cap_hi,
  input  logic              cap_lo,
  input  logic [1:0]        gain_sel,
  input  logic [2:0]        rate_sel,
  input  logic              hpf_s,
  output logic [GAIN_W-1:0] gain_x,
  output logic [2:0]        rate,
  output logic [1:0]        hpf
);

  logic [GAIN_W-1:0] gain_q;
  logic [2:0]        rate_q;
  logic              seen_hi_q;
  hpf_mode_e         hpf_q, hpf_d;

  always_comb begin
    hpf_d = hpf_decode(seen_hi_q, hpf_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
      rate_q <= '0;
    end else if (cap_cfg) begin
      gain_q <= gain_mult(gain_sel);
      rate_q <= rate_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seen_hi_q <= 1'b0;
    else if (cap_hi) seen_hi_q <= hpf_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hpf_q <= HPF_NONE;
    else if (cap_lo) hpf_q <= hpf_d;
  end

  assign gain_x = gain_q;
  assign rate   = rate_q;
  assign hpf    = hpf_q;

endmodule

// File: rtl/pwrup_cfg_ctrl.sv
module pwrup_cfg_ctrl
  import pwrup_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 8
) (
  input  logic        clk,
  input  logic        supply_ok,
  input  logic        ext_rst_n,
  input  logic [1:0]  gain_sel,
  input  logic [2:0]  rate_sel,
  input  logic        hpf_pin,
  output logic        cal_probe_en,
  output logic        cal_probe_lvl,
  output logic [7:0]  cfg_gain_x,
  output logic [2:0]  cfg_rate,
  output logic [1:0]  cfg_hpf,
  output logic        run_en
);

  // Each probe level is held until the synchronised pin reflects it.
  localparam int PROBE_LEN = SYNC_STAGES + 1;

  logic arst_n;
  logic rst_sync_n;
  logic hpf_s;
  logic cap_cfg, cap_hi, cap_lo;

  assign arst_n = supply_ok & ext_rst_n;

  cfg_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      (1'b1),
    .q      (rst_sync_n)
  );

  cfg_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b0)) u_hpf_sync (
    .clk    (clk),
    .arst_n (rst_sync_n),
    .d      (hpf_pin),
    .q      (hpf_s)
  );

  cfg_seq #(.SETTLE_CYC(SETTLE_CYC), .PROBE_LEN(PROBE_LEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .probe_en  (cal_probe_en),
    .probe_lvl (cal_probe_lvl),
    .cap_cfg   (cap_cfg),
    .cap_hi    (cap_hi),
    .cap_lo    (cap_lo),
    .run_en    (run_en)
  );

  cfg_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cap_cfg  (cap_cfg),
    .cap_hi   (cap_hi),
    .cap_lo   (cap_lo),
    .gain_sel (gain_sel),
    .rate_sel (rate_sel),
    .hpf_s    (hpf_s),
    .gain_x   (cfg_gain_x),
    .rate     (cfg_rate),
    .hpf      (cfg_hpf)
  );

endmodule

// File: rtl/pwrup_cfg_chk.sv
module pwrup_cfg_chk (
  input logic       clk,
  input logic       supply_ok,
  input logic       ext_rst_n,
  input logic       cal_probe_en,
  input logic       cal_probe_lvl,
  input logic [7:0] cfg_gain_x,
  input logic [2:0] cfg_rate,
  input logic [1:0] cfg_hpf,
  input logic       run_en
);

  logic rst_act;
  assign rst_act = !(supply_ok && ext_rst_n);

  // R9: the probe never overlaps measurement
  p_probe_excl_r9: assert property (@(posedge clk) disable iff (rst_act)
    cal_probe_en |-> !run_en);

  // R9: once the low window starts the level stays low
  p_probe_order_r9: assert property (@(posedge clk) disable iff (rst_act)
    (cal_probe_en && !cal_probe_lvl) |=> !cal_probe_lvl);

  // R9: level is only driven while the probe is active
  p_probe_idle_r9: assert property (@(posedge clk) disable iff (rst_act)
    !cal_probe_en |-> !cal_probe_lvl);

  // R3: run begins straight after the probe windows
  p_run_after_probe_r3: assert property (@(posedge clk) disable iff (rst_act)
    $rose(run_en) |-> $past(cal_probe_en));

  // R10: run and settings hold until reset
  p_run_sticky_r10: assert property (@(posedge clk) disable iff (rst_act)
    run_en |=> run_en);

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (rst_act)
    run_en |=> ($stable(cfg_gain_x) && $stable(cfg_rate) && $stable(cfg_hpf)));

  // R4: latched gain is one of the four multipliers
  p_gain_legal_r4: assert property (@(posedge clk) disable iff (rst_act)
    run_en |-> (cfg_gain_x == 8'd10 || cfg_gain_x == 8'd50 ||
                cfg_gain_x == 8'd100 || cfg_gain_x == 8'd150));

  // R6: filter code 11 is never produced
  p_hpf_legal_r6: assert property (@(posedge clk) disable iff (rst_act)
    cfg_hpf != 2'b11);

endmodule

bind pwrup_cfg_ctrl pwrup_cfg_chk u_chk (
  .clk           (clk),
  .supply_ok     (supply_ok),
  .ext_rst_n     (ext_rst_n),
  .cal_probe_en  (cal_probe_en),
  .cal_probe_lvl (cal_probe_lvl),
  .cfg_gain_x    (cfg_gain_x),
  .cfg_rate      (cfg_rate),
  .cfg_hpf       (cfg_hpf),
  .run_en        (run_en)
);

// File: tb/sim_pwrup_cfg_ctrl.sv
`timescale 1ns/1ps
module sim_pwrup_cfg_ctrl;

  logic       clk;
  logic       supply_ok;
  logic       ext_rst_n;
  logic [1:0] gain_sel;
  logic [2:0] rate_sel;
  logic       hpf_pin;
  logic       cal_probe_en;
  logic       cal_probe_lvl;
  logic [7:0] cfg_gain_x;
  logic [2:0] cfg_rate;
  logic [1:0] cfg_hpf;
  logic       run_en;

  // board model of the filter strap: 0 high, 1 low, 2 wired to cal output, 3 inverted echo
  int tie_mode;
  int n_run;
  int n_fail;
  bit done;

  always_comb begin
    case (tie_mode)
      0:       hpf_pin = 1'b1;
      1:       hpf_pin = 1'b0;
      2:       hpf_pin = cal_probe_lvl;
      default: hpf_pin = ~cal_probe_lvl;
    endcase
  end

  initial clk = 1'b0;
  always #4 clk = ~clk;

  pwrup_cfg_ctrl u0 (
    .clk           (clk),
    .supply_ok     (supply_ok),
    .ext_rst_n     (ext_rst_n),
    .gain_sel      (gain_sel),
    .rate_sel      (rate_sel),
    .hpf_pin       (hpf_pin),
    .cal_probe_en  (cal_probe_en),
    .cal_probe_lvl (cal_probe_lvl),
    .cfg_gain_x    (cfg_gain_x),
    .cfg_rate      (cfg_rate),
    .cfg_hpf       (cfg_hpf),
    .run_en        (run_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_reset_vals(input string req);
    check(req, {31'd0, run_en}, 0);
    check(req, {31'd0, cal_probe_en}, 0);
    check(req, {31'd0, cal_probe_lvl}, 0);
    check(req, {24'd0, cfg_gain_x}, 0);
    check(req, {29'd0, cfg_rate}, 0);
    check(req, {30'd0, cfg_hpf}, 0);
  endtask

  // Raise both reset sources at a falling edge and follow each rising edge.
  task automatic bring_up;
    @(negedge clk);
    supply_ok = 1'b1;
    ext_rst_n = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R3 run_en timing", {31'd0, run_en}, (i >= 16) ? 1 : 0);
      check("R9 probe_en window", {31'd0, cal_probe_en}, (i >= 10 && i <= 15) ? 1 : 0);
      check("R9 probe level", {31'd0, cal_probe_lvl}, (i >= 10 && i <= 12) ? 1 : 0);
    end
  endtask

  task automatic power_down;
    @(negedge clk);
    supply_ok = 1'b0;
    #1;
    check_reset_vals("R1 supply low");
    repeat (3) @(negedge clk);
  endtask

  function automatic int gain_exp(input logic [1:0] c);
    case (c)
      2'b00:   return 10;
      2'b01:   return 50;
      2'b10:   return 100;
      default: return 150;
    endcase
  endfunction

  task automatic t_reset_hold;
    supply_ok = 1'b0;
    ext_rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check_reset_vals("R1 held in reset");
  endtask

  task automatic t_gain_rate;
    for (int g = 0; g < 4; g++) begin
      gain_sel = 2'(g);
      rate_sel = 3'(7 - g);
      tie_mode = 0;
      bring_up();
      check("R4 gain multiplier", {24'd0, cfg_gain_x}, gain_exp(2'(g)));
      check("R5 rate latched", {29'd0, cfg_rate}, 7 - g);
      check("R11 recapture after power cycle", {30'd0, cfg_hpf}, 0);
      power_down();
    end
  endtask

  task automatic t_hpf_modes;
    for (int m = 0; m < 4; m++) begin
      tie_mode = m;
      bring_up();
      case (m)
        0: check("R6 pin high -> none", {30'd0, cfg_hpf}, 0);
        1: check("R7 pin low -> voltage", {30'd0, cfg_hpf}, 1);
        2: check("R8 pin tied -> current", {30'd0, cfg_hpf}, 2);
        default: check("R12 inverted echo -> none", {30'd0, cfg_hpf}, 0);
      endcase
      power_down();
    end
  endtask

  task automatic t_ignore_changes;
    gain_sel = 2'b10;
    rate_sel = 3'd5;
    tie_mode = 2;
    bring_up();
    @(negedge clk);
    gain_sel = 2'b01;
    rate_sel = 3'd2;
    tie_mode = 0;
    repeat (20) @(negedge clk);
    check("R10 gain frozen", {24'd0, cfg_gain_x}, 100);
    check("R10 rate frozen", {29'd0, cfg_rate}, 5);
    check("R10 filter frozen", {30'd0, cfg_hpf}, 2);
    check("R10 run held", {31'd0, run_en}, 1);
    power_down();
  endtask

  task automatic t_pin_reset;
    gain_sel = 2'b11;
    rate_sel = 3'd3;
    tie_mode = 1;
    bring_up();
    @(negedge clk);
    ext_rst_n = 1'b0;
    #1;
    check_reset_vals("R2 pin reset immediate");
    repeat (30) @(negedge clk);
    check_reset_vals("R2 pin reset held with supply high");
    gain_sel = 2'b00;
    bring_up();
    check("R2 recapture after pin reset", {24'd0, cfg_gain_x}, 10);
    check("R7 low strap after pin reset", {30'd0, cfg_hpf}, 1);
  endtask

  initial begin
    n_run = 0;
    n_fail = 0;
    done = 1'b0;
    tie_mode = 0;
    gain_sel = 2'b00;
    rate_sel = 3'd0;
    supply_ok = 1'b0;
    ext_rst_n = 1'b0;
    t_reset_hold();
    t_gain_rate();
    t_hpf_modes();
    t_ignore_changes();
    t_pin_reset();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule